// File: doc/BRIEF.md
# SPI Flash Command Guard with Write-Enable Latch

This block is the command front end of a serial NOR flash as seen from the SPI pins. It assembles opcodes and their trailing bytes MSB first while chip select is low. It keeps the write-enable latch that every modifying command depends on. It turns accepted program, erase and status-write frames into single-cycle start strobes for the memory-array controller that sits behind it.

Every strobe carries the captured 24-bit address and an abort flag. The abort flag is set when the frame closed at the wrong length, or when chip select rose partway through a byte. A modifying command that arrives while the latch is clear leaves no trace at all. While the controller reports busy, the block ignores every command except the wake/signature command. The latch clears when the controller signals completion.

The block also handles the wake command. It pulses a wake strobe when that opcode arrives. If the frame continues past three dummy bytes, it keeps sending a fixed signature byte on the output line for as long as the master supplies clocks.

The SPI pins are sampled by the block's own system clock, which must run several times faster than the serial clock. Page-program and status-write payload bytes leave on a plain valid strobe with no ready signal. The serial link cannot be paused, so each byte is shown for exactly one cycle and the receiver must take it in that cycle.

Top module: `spi_wel_guard`

## Requirements
- R1: After reset the latch output `wel` is 0, `spi_miso_oe` is 0, and no strobe, wake or data-valid pulse is issued until a frame arrives.
- R2: Opcode 06h sets the latch only if chip select rises after exactly 8 serial clocks. A shorter or longer frame leaves the latch unchanged.
- R3: Opcode 04h clears the latch under the same exact-8-clock framing. Any other framing leaves the latch unchanged.
- R4: A one-cycle pulse on `op_done` clears the latch.
- R5: A modifying opcode (01h, 02h, D8h, C7h) that completes while the latch is clear produces no start strobe and no data-valid pulse, and the latch stays clear.
- R6: For opcode D8h, `se_go` pulses once after chip select rises. `op_addr` holds bytes 1 to 3 of the frame, first byte most significant. `op_abort` is 0 only when the frame held exactly 4 whole bytes.
- R7: For opcode C7h, `be_go` pulses once after chip select rises. `op_abort` is 0 only when the frame held exactly 1 whole byte.
- R8: For opcode 02h, bytes 1 to 3 form `op_addr` and every later byte appears on `wr_data` with a `wr_valid` pulse. `pp_go` pulses after chip select rises, and `op_abort` is 0 only when the frame held at least 5 whole bytes and ended on a byte boundary.
- R9: For opcode 01h, every byte after the opcode appears on `wr_data` with a `wr_valid` pulse. `wrsr_go` pulses after chip select rises, and `op_abort` is 0 only when the frame held at least 2 whole bytes and ended on a byte boundary.
- R10: While `busy` is high, opcodes 06h, 04h, 01h, 02h, D8h and C7h have no effect: no strobe, no data pulse, and no change to the latch.
- R11: Opcode ABh pulses `wake` when its eighth bit arrives, whatever the state of `busy`. If chip select rises right after the opcode, nothing is driven on the output line.
- R12: After opcode ABh and 3 further bytes, the signature byte (parameter, default 13h) is driven MSB first and repeats without end. A new bit appears on each falling serial clock edge, with `spi_miso_oe` high. The enable drops within one cycle of chip select going high and is low at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the serial clock rate |
| rst_n | input | 1 | Active-low reset (power-up) |
| spi_clk | input | 1 | Serial clock, mode 0, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in, sampled on rising serial clock |
| spi_miso | output | 1 | Serial data out, updated on falling serial clock |
| spi_miso_oe | output | 1 | Output enable for the serial data out pin |
| busy | input | 1 | Array controller has an operation in progress |
| op_done | input | 1 | One-cycle completion pulse from the array controller |
| wel | output | 1 | Write-enable latch state |
| wake | output | 1 | One-cycle pulse when the wake/signature opcode arrives |
| pp_go | output | 1 | Page-program start strobe |
| se_go | output | 1 | Sector-erase start strobe |
| be_go | output | 1 | Bulk-erase start strobe |
| wrsr_go | output | 1 | Status-write start strobe |
| op_abort | output | 1 | Frame of the current strobe was malformed |
| op_addr | output | 24 | Captured address for the current strobe |
| wr_data | output | 8 | Payload byte for program or status write |
| wr_valid | output | 1 | One-cycle strobe qualifying `wr_data` |

## Verification
Each result has its own delay. A start strobe appears one system cycle after chip select is first seen high, and the latch moves one cycle after that. A payload byte is valid two cycles after the system clock first sees the rising serial edge that completes the byte. The output bit changes in the same cycle that the falling serial edge is first seen. The bench holds each serial clock phase and the idle gap after chip select for several system cycles. It samples the output pin just before each rising edge. It counts strobes and payload pulses in a monitor, so it reads them as totals taken after the frame has fully settled rather than at one exact cycle.

// File: rtl/wguard_pkg.sv
package wguard_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [BYTE_W-1:0] {
    OP_WRSR = 8'h01,
    OP_PP   = 8'h02,
    OP_WRDI = 8'h04,
    OP_WREN = 8'h06,
    OP_SIG  = 8'hAB,
    OP_BE   = 8'hC7,
    OP_SE   = 8'hD8
  } opcode_e;

  function automatic logic is_modify(input logic [BYTE_W-1:0] op);
    return (op == OP_WRSR) || (op == OP_PP) || (op == OP_BE) || (op == OP_SE);
  endfunction

  function automatic logic has_addr(input logic [BYTE_W-1:0] op);
    return (op == OP_PP) || (op == OP_SE);
  endfunction
endpackage

// File: rtl/wg_shifter.sv
module wg_shifter
  import wguard_pkg::*;
#(
  parameter int CNT_W = 4,
  localparam int IDX_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              fall_o,
  output logic              cs_rise_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [CNT_W-1:0]  byte_num_o,
  output logic [CNT_W-1:0]  byte_cnt_o,
  output logic [IDX_W-1:0]  bit_idx_o
);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(BYTE_W - 1);

  logic              sclk_q, cs_q;
  logic [BYTE_W-1:0] sr;
  logic              rise;

  assign rise      = sclk & ~sclk_q & ~cs_n;
  assign fall_o    = ~sclk & sclk_q & ~cs_n;
  assign cs_rise_o = cs_n & ~cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      sr         <= '0;
      bit_idx_o  <= '0;
      byte_cnt_o <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      byte_num_o <= '0;
    end else begin
      sclk_q     <= sclk;
      cs_q       <= cs_n;
      byte_vld_o <= 1'b0;
      if (cs_n) begin
        bit_idx_o  <= '0;
        byte_cnt_o <= '0;
      end else if (rise) begin
        sr <= {sr[BYTE_W-2:0], mosi};
        if (bit_idx_o == LAST_BIT) begin
          bit_idx_o  <= '0;
          byte_vld_o <= 1'b1;
          byte_o     <= {sr[BYTE_W-2:0], mosi};
          byte_num_o <= byte_cnt_o;
          if (byte_cnt_o != '1) byte_cnt_o <= byte_cnt_o + 1'b1;
        end else begin
          bit_idx_o <= bit_idx_o + 1'b1;
        end
      end
    end
  end

  // R2
  frame_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (bit_idx_o == '0) && (byte_cnt_o == '0));
endmodule

// File: rtl/wg_wel.sv
module wg_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic done_i,
  output logic wel_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wel_o <= 1'b0;
    else if (clr_i || done_i) wel_o <= 1'b0;
    else if (set_i)          wel_o <= 1'b1;
  end

  // R4
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !wel_o);

  // R2
  set_only_by_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_o) |-> $past(set_i));
endmodule

// File: rtl/wg_sig_tx.sv
module wg_sig_tx
  import wguard_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SIG_BYTE = 8'h13,
  localparam int IDX_W = $clog2(BYTE_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             fall_i,
  input  logic             active_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  output logic             miso_o,
  output logic             oe_o
);
  localparam logic [IDX_W-1:0] TOP_BIT = IDX_W'(BYTE_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miso_o <= 1'b0;
      oe_o   <= 1'b0;
    end else if (cs_n) begin
      miso_o <= 1'b0;
      oe_o   <= 1'b0;
    end else if (fall_i) begin
      oe_o   <= active_i;
      miso_o <= active_i ? SIG_BYTE[TOP_BIT - bit_idx_i] : 1'b0;
    end
  end

  // R12
  oe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_o |-> !$past(cs_n));
endmodule

// File: rtl/spi_wel_guard.sv
module spi_wel_guard
  import wguard_pkg::*;
#(
  parameter int                ADDR_BYTES  = 3,
  parameter int                DUMMY_BYTES = 3,
  parameter logic [BYTE_W-1:0] SIG_BYTE    = 8'h13,
  localparam int ADDR_W = ADDR_BYTES * BYTE_W,
  localparam int CNT_W  = $clog2(ADDR_BYTES + DUMMY_BYTES + 2) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_clk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              busy,
  input  logic              op_done,
  output logic              wel,
  output logic              wake,
  output logic              pp_go,
  output logic              se_go,
  output logic              be_go,
  output logic              wrsr_go,
  output logic              op_abort,
  output logic [ADDR_W-1:0] op_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_valid
);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] SE_LEN  = CNT_W'(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] PP_MIN  = CNT_W'(ADDR_BYTES + 2);
  localparam logic [CNT_W-1:0] SIG_MIN = CNT_W'(DUMMY_BYTES + 1);
  localparam logic [CNT_W-1:0] ADDR_HI = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO     = CNT_W'(2);

  logic              sclk_fall, cs_rise, byte_vld;
  logic [BYTE_W-1:0] byte_data;
  logic [CNT_W-1:0]  byte_num, byte_cnt;
  logic [IDX_W-1:0]  bit_idx;
  logic              aligned;

  logic [BYTE_W-1:0] opcode;
  logic              op_valid, acc;
  logic              wel_set, wel_clr;
  logic              sig_active;

  wg_shifter #(.CNT_W(CNT_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (spi_clk),
    .cs_n       (spi_cs_n),
    .mosi       (spi_mosi),
    .fall_o     (sclk_fall),
    .cs_rise_o  (cs_rise),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_data),
    .byte_num_o (byte_num),
    .byte_cnt_o (byte_cnt),
    .bit_idx_o  (bit_idx)
  );

  assign aligned    = (bit_idx == '0);
  assign sig_active = op_valid && (opcode == OP_SIG) && (byte_cnt >= SIG_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode   <= '0;
      op_valid <= 1'b0;
      acc      <= 1'b0;
      op_addr  <= '0;
      op_abort <= 1'b0;
      pp_go    <= 1'b0;
      se_go    <= 1'b0;
      be_go    <= 1'b0;
      wrsr_go  <= 1'b0;
      wel_set  <= 1'b0;
      wel_clr  <= 1'b0;
      wake     <= 1'b0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else begin
      pp_go    <= 1'b0;
      se_go    <= 1'b0;
      be_go    <= 1'b0;
      wrsr_go  <= 1'b0;
      wel_set  <= 1'b0;
      wel_clr  <= 1'b0;
      wake     <= 1'b0;
      wr_valid <= 1'b0;
      if (cs_rise) begin
        op_valid <= 1'b0;
        acc      <= 1'b0;
        if (op_valid) begin
          case (opcode)
            OP_WREN: if (byte_cnt == ONE && aligned && !busy) wel_set <= 1'b1;
            OP_WRDI: if (byte_cnt == ONE && aligned && !busy) wel_clr <= 1'b1;
            OP_SE: if (acc) begin
              se_go    <= 1'b1;
              op_abort <= !(aligned && byte_cnt == SE_LEN);
            end
            OP_BE: if (acc) begin
              be_go    <= 1'b1;
              op_abort <= !(aligned && byte_cnt == ONE);
            end
            OP_PP: if (acc) begin
              pp_go    <= 1'b1;
              op_abort <= !(aligned && byte_cnt >= PP_MIN);
            end
            OP_WRSR: if (acc) begin
              wrsr_go  <= 1'b1;
              op_abort <= !(aligned && byte_cnt >= TWO);
            end
            default: ;
          endcase
        end
      end else if (byte_vld) begin
        if (byte_num == '0) begin
          opcode   <= byte_data;
          op_valid <= 1'b1;
          acc      <= wel && !busy && is_modify(byte_data);
          op_addr  <= '0;
          if (byte_data == OP_SIG) wake <= 1'b1;
        end else begin
          if (has_addr(opcode) && byte_num <= ADDR_HI)
            op_addr <= {op_addr[ADDR_W-BYTE_W-1:0], byte_data};
          if (acc && ((opcode == OP_PP && byte_num > ADDR_HI) || opcode == OP_WRSR)) begin
            wr_valid <= 1'b1;
            wr_data  <= byte_data;
          end
        end
      end
    end
  end

  wg_wel u_wel (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (wel_set),
    .clr_i  (wel_clr),
    .done_i (op_done),
    .wel_o  (wel)
  );

  wg_sig_tx #(.SIG_BYTE(SIG_BYTE)) u_sig (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (spi_cs_n),
    .fall_i    (sclk_fall),
    .active_i  (sig_active),
    .bit_idx_i (bit_idx),
    .miso_o    (spi_miso),
    .oe_o      (spi_miso_oe)
  );

  // R6
  strobe_after_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pp_go || se_go || be_go || wrsr_go) |-> $past(spi_cs_n));

  // R10
  busy_holds_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(busy, 2)) |-> !$rose(wel));
endmodule

// File: tb/sim_spi_wel_guard.sv
module sim_spi_wel_guard;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;
  localparam logic [7:0] SIG = 8'h13;

  logic clk = 0, rst_n = 0;
  logic spi_clk = 0, spi_cs_n = 1, spi_mosi = 0, busy = 0, op_done = 0;
  logic spi_miso, spi_miso_oe, wel, wake, pp_go, se_go, be_go, wrsr_go, op_abort, wr_valid;
  logic [23:0] op_addr;
  logic [7:0]  wr_data;

  always #(CLK_P/2) clk = ~clk;

  spi_wel_guard #(.SIG_BYTE(SIG)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_clk(spi_clk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .busy(busy), .op_done(op_done),
    .wel(wel), .wake(wake), .pp_go(pp_go), .se_go(se_go), .be_go(be_go), .wrsr_go(wrsr_go),
    .op_abort(op_abort), .op_addr(op_addr), .wr_data(wr_data), .wr_valid(wr_valid));

  int n_chk = 0, n_fail = 0;
  int n_pp = 0, n_se = 0, n_be = 0, n_wr = 0, n_data = 0, n_wake = 0, n_oe = 0, n_any = 0;
  logic [7:0]  last_data = 0;
  logic        last_abort = 0;
  logic [23:0] last_addr = 0;

  always @(posedge clk) if (rst_n) begin
    if (pp_go) n_pp++;
    if (se_go) n_se++;
    if (be_go) n_be++;
    if (wrsr_go) n_wr++;
    if (pp_go | se_go | be_go | wrsr_go) begin last_abort = op_abort; last_addr = op_addr; end
    if (wr_valid) begin n_data++; last_data = wr_data; end
    if (wake) n_wake++;
    if (spi_miso_oe) n_oe++;
    if (pp_go | se_go | be_go | wrsr_go | wake | wr_valid) n_any++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [47:0] bits, input int n,
                       output logic [47:0] rd, output logic [47:0] rd_oe);
    rd = '0; rd_oe = '0;
    spi_cs_n = 0;
    tick(HALF);
    for (int i = 0; i < n; i++) begin
      spi_mosi = bits[47-i];
      tick(HALF);
      rd[47-i] = spi_miso;
      rd_oe[47-i] = spi_miso_oe;
      spi_clk = 1;
      tick(HALF);
      spi_clk = 0;
    end
    tick(HALF);
    spi_cs_n = 1;
    tick(8);
  endtask

  task automatic send(input logic [47:0] bits, input int n);
    logic [47:0] a, b;
    frame(bits, n, a, b);
  endtask

  task automatic pulse_done;
    op_done = 1; tick(1); op_done = 0; tick(2);
  endtask

  typedef struct packed {
    logic        pre_wren;
    logic        busy;
    logic [5:0]  nbits;
    logic [47:0] bits;
    logic [2:0]  kind;   // 0 none, 1 pp, 2 se, 3 be, 4 wrsr
    logic        abort;
    logic [23:0] addr;
    logic        wel;
    logic [3:0]  ndata;
    logic [7:0]  last;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 6'd32, 48'hD8_12_34_56_00_00, 3'd2, 1'b0, 24'h123456, 1'b1, 4'd0, 8'h00}, // R6
    '{1'b0, 1'b0, 6'd32, 48'hD8_12_34_56_00_00, 3'd0, 1'b0, 24'h000000, 1'b0, 4'd0, 8'h00}, // R5
    '{1'b1, 1'b0, 6'd8,  48'hC7_00_00_00_00_00, 3'd3, 1'b0, 24'h000000, 1'b1, 4'd0, 8'h00}, // R7
    '{1'b1, 1'b0, 6'd48, 48'h02_00_01_FF_A5_5A, 3'd1, 1'b0, 24'h0001FF, 1'b1, 4'd2, 8'h5A}, // R8
    '{1'b1, 1'b0, 6'd24, 48'hD8_12_34_00_00_00, 3'd2, 1'b1, 24'h000000, 1'b1, 4'd0, 8'h00}, // R6
    '{1'b1, 1'b1, 6'd32, 48'hD8_12_34_56_00_00, 3'd0, 1'b0, 24'h000000, 1'b1, 4'd0, 8'h00}, // R10
    '{1'b1, 1'b0, 6'd16, 48'h01_3C_00_00_00_00, 3'd4, 1'b0, 24'h000000, 1'b1, 4'd1, 8'h3C}, // R9
    '{1'b1, 1'b0, 6'd43, 48'h02_AA_BB_CC_DD_E0, 3'd1, 1'b1, 24'h000000, 1'b1, 4'd1, 8'hDD}, // R8
    '{1'b1, 1'b0, 6'd9,  48'hC7_80_00_00_00_00, 3'd3, 1'b1, 24'h000000, 1'b1, 4'd0, 8'h00}, // R7
    '{1'b0, 1'b0, 6'd48, 48'h02_00_01_FF_A5_5A, 3'd0, 1'b0, 24'h000000, 1'b0, 4'd0, 8'h00}  // R5
  };

  function automatic string vtag(input vec_t v);
    if (v.busy) return "R10";
    if (!v.pre_wren) return "R5";
    case (v.kind)
      3'd1: return "R8";
      3'd2: return "R6";
      3'd3: return "R7";
      default: return "R9";
    endcase
  endfunction

  localparam logic [47:0] WREN = 48'h06_00_00_00_00_00;
  localparam logic [47:0] WRDI = 48'h04_00_00_00_00_00;

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] rd, rdoe;
    int pp0, se0, be0, wr0, d0, wk0, oe0, any0;
    tick(5);
    rst_n = 1;
    tick(5);
    // R1 reset state
    chk("R1 wel", wel, 0);
    chk("R1 oe", spi_miso_oe, 0);
    chk("R1 pulses", n_any, 0);

    for (int k = 0; k < NV; k++) begin
      busy = 0;
      send(WRDI, 8);
      if (VECS[k].pre_wren) send(WREN, 8);
      busy = VECS[k].busy;
      pp0 = n_pp; se0 = n_se; be0 = n_be; wr0 = n_wr; d0 = n_data;
      send(VECS[k].bits, int'(VECS[k].nbits));
      chk({vtag(VECS[k]), " pp count"},   n_pp - pp0, (VECS[k].kind == 3'd1) ? 1 : 0);
      chk({vtag(VECS[k]), " se count"},   n_se - se0, (VECS[k].kind == 3'd2) ? 1 : 0);
      chk({vtag(VECS[k]), " be count"},   n_be - be0, (VECS[k].kind == 3'd3) ? 1 : 0);
      chk({vtag(VECS[k]), " wrsr count"}, n_wr - wr0, (VECS[k].kind == 3'd4) ? 1 : 0);
      chk({vtag(VECS[k]), " data count"}, n_data - d0, 32'(VECS[k].ndata));
      chk({vtag(VECS[k]), " wel"}, wel, VECS[k].wel);
      if (VECS[k].kind != 3'd0) chk({vtag(VECS[k]), " abort"}, last_abort, VECS[k].abort);
      if (!VECS[k].abort && (VECS[k].kind == 3'd1 || VECS[k].kind == 3'd2))
        chk({vtag(VECS[k]), " addr"}, last_addr, VECS[k].addr);
      if (VECS[k].ndata != 0) chk({vtag(VECS[k]), " last data"}, last_data, VECS[k].last);
      busy = 0;
      pulse_done();
      chk("R4 done clears", wel, 0);
    end

    // R2 framing of the enable opcode
    send(WRDI, 8);
    send(WREN, 9);
    chk("R2 nine clocks ignored", wel, 0);
    send(WREN, 7);
    chk("R2 seven clocks ignored", wel, 0);
    send(WREN, 8);
    chk("R2 exact frame sets", wel, 1);
    // R3 framing of the disable opcode
    send(WRDI, 12);
    chk("R3 misaligned disable ignored", wel, 1);
    send(WRDI, 8);
    chk("R3 disable clears", wel, 0);
    // R4 completion
    send(WREN, 8);
    pulse_done();
    chk("R4 completion clears", wel, 0);
    // R10 busy blocks latch commands
    busy = 1;
    send(WREN, 8);
    chk("R10 enable while busy", wel, 0);
    busy = 0;
    send(WREN, 8);
    busy = 1;
    send(WRDI, 8);
    chk("R10 disable while busy", wel, 1);

    // R11 wake alone, while busy
    wk0 = n_wake; oe0 = n_oe; any0 = n_any;
    send(48'hAB_00_00_00_00_00, 8);
    chk("R11 wake pulse", n_wake - wk0, 1);
    chk("R11 no output drive", n_oe - oe0, 0);
    busy = 0;
    chk("R11 latch untouched", wel, 1);

    // R12 signature stream
    frame(48'hAB_00_00_00_00_00, 48, rd, rdoe);
    chk("R12 signature bits", rd[15:0], {SIG, SIG});
    chk("R12 oe while streaming", rdoe[15:0], 16'hFFFF);
    chk("R12 oe during dummies", rdoe[47:16], 32'h0);
    chk("R12 oe after deselect", spi_miso_oe, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule